// File: doc/BRIEF.md
# Three-Byte I2C Write Receiver

This block is a receive-only I2C target. It watches an oversampled SCL/SDA pair on its own system clock and recognises START and STOP conditions. It takes in the target address byte and pulls SDA low in the acknowledge slot when the address matches. A match is either the 7-bit address on its address input or a fixed broadcast address set by a parameter. The write bit must also be 0.

After a matching address, the block collects data bytes. It acknowledges the first three. When the third one completes, it emits all three as one 24-bit command word with a single-cycle strobe. Any later byte in the same frame gets no acknowledge. A frame that ends early, through STOP or a repeated START, produces no word.

The block does not support reads or clock stretching. It treats the address input as a plain binary value.

Top module: `i2c_word_rx`

## Requirements
- R1: While reset is held low, and in the cycle after it, `sda_pull` is 0 and `word_valid` is 0.
- R2: After a START, an address byte is acknowledged in its 9th clock (`sda_pull` = 1 while SCL is high) when its upper 7 bits equal `dev_addr` and its last bit (the write bit) is 0.
- R3: An address byte whose upper 7 bits equal the parameter `GLOBAL_ADDR` (default 7'h73) and whose write bit is 0 is acknowledged whatever value `dev_addr` has.
- R4: An address that matches neither, or a write bit of 1, is not acknowledged. Every later byte up to the next START is then not acknowledged, and no word is produced.
- R5: After an acknowledged address, each of the first three data bytes is acknowledged in its 9th clock.
- R6: Data bits are taken MSB first. Byte 1 lands in `word_out[23:16]`, byte 2 in `[15:8]` and byte 3 in `[7:0]`. `word_valid` is high for exactly one cycle per completed word, during the acknowledge of byte 3.
- R7: Data bytes after the third in one frame are not acknowledged, and they produce no further word.
- R8: A STOP or a repeated START received before byte 3 completes discards the partial word with no strobe. A repeated START begins a new frame that is decoded normally.
- R9: `dev_addr` is captured at each START. Changing it later in the frame does not change that frame's address decision.
- R10: `sda_pull` changes only while SCL is low. It rises after the SCL fall that ends bit 8 of a byte and drops after the SCL fall that ends bit 9. It is 0 during every SCL-high phase other than an acknowledged 9th clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples SCL and SDA |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | SCL as seen on the bus |
| sda_in | input | 1 | SDA as seen on the bus (wired-AND including this block's drive) |
| dev_addr | input | 7 | Selected 7-bit target address, captured at START |
| sda_pull | output | 1 | 1 = pull SDA low (acknowledge) |
| word_out | output | 24 | Last assembled command word |
| word_valid | output | 1 | One-cycle strobe: `word_out` holds a new word |

## Verification
The hardest situation to reach from the ports is a frame that starts to match and is then cut short. Examples are a repeated START after two acknowledged bytes, a fourth byte after a full word, and an address-input change in the middle of a frame. The bench master drives the wired-AND bus at bit level, with every phase lasting ten system clocks. It chains such frames back to back. A behavioural model decides, from the captured address and the byte index, whether each acknowledge slot should pull SDA low and which words must appear. The model compares SDA drive in every SCL-high cycle and checks the word strobe in every cycle.

// File: rtl/i2c_word_rx_pkg.sv
// Shared types for the three-byte I2C write receiver.
// Assumes: nothing beyond IEEE 1800-2017.
package i2c_word_rx_pkg;

    // Frame sequencer states
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ADDR     = 3'd1,
        ST_ADDR_ACK = 3'd2,
        ST_DATA     = 3'd3,
        ST_DATA_ACK = 3'd4,
        ST_IGNORE   = 3'd5
    } frame_st_t;

    localparam int BITS_PER_BYTE = 8;

endpackage

// File: rtl/i2c_line_sync.sv
// Multi-stage synchroniser with edge detection for a group of lines.
// Assumes: lines idle high (open-drain bus), so every stage resets to 1.
module i2c_line_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] synced,
    output logic [LINES-1:0] rise,
    output logic [LINES-1:0] fall
);

    generate
        for (genvar l = 0; l < LINES; l++) begin : g_line
            logic [STAGES-1:0] chain;
            logic              prev;

            // Shift the raw line through the synchroniser chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], raw[l]};
            end

            // Remember last synchronised value for edge detection
            always_ff @(posedge clk) begin
                if (!rst_n) prev <= 1'b1;
                else        prev <= chain[STAGES-1];
            end

            assign synced[l] = chain[STAGES-1];
            assign rise[l]   = chain[STAGES-1] & ~prev;
            assign fall[l]   = ~chain[STAGES-1] & prev;
        end
    endgenerate

endmodule

// File: rtl/i2c_frame_ctrl.sv
// Frame sequencer: address decode, bit counting, ACK drive, byte hand-off.
// Assumes: synchronised SCL/SDA with one-cycle edge flags; START/STOP flags
// already qualified by the caller. ACK is driven from an SCL fall to the next.
module i2c_frame_ctrl
    import i2c_word_rx_pkg::*;
#(
    parameter logic [6:0] GLOBAL_ADDR = 7'h73,
    parameter int         BYTES       = 3,
    localparam int        IDX_W       = $clog2(BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [6:0]       dev_addr,
    output logic             sda_pull,
    output logic             byte_stb,
    output logic [IDX_W-1:0] byte_idx,
    output logic [7:0]       byte_data,
    output frame_st_t        state
);

    localparam logic [3:0] LAST_BIT = 4'(BITS_PER_BYTE);

    frame_st_t        st;
    logic [3:0]       bit_cnt;
    logic [7:0]       shreg;
    logic [IDX_W-1:0] byte_cnt;
    logic [6:0]       addr_q;
    logic             addr_ok;
    logic             byte_end;
    logic             room;

    // Decode the received address byte against both accepted addresses
    always_comb begin
        addr_ok = ((shreg[7:1] == addr_q) || (shreg[7:1] == GLOBAL_ADDR)) && !shreg[0];
    end

    assign byte_end = scl_fall && (bit_cnt == LAST_BIT);
    assign room     = (byte_cnt < IDX_W'(BYTES));

    // Sequence the frame: shift bits, decide ACK, track byte count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            byte_cnt <= '0;
            addr_q   <= '0;
            sda_pull <= 1'b0;
        end else if (start_det) begin
            st       <= ST_ADDR;
            bit_cnt  <= '0;
            byte_cnt <= '0;
            addr_q   <= dev_addr;
            sda_pull <= 1'b0;
        end else if (stop_det) begin
            st       <= ST_IDLE;
            bit_cnt  <= '0;
            sda_pull <= 1'b0;
        end else begin
            case (st)
                ST_ADDR, ST_DATA: begin
                    if (scl_rise && bit_cnt != LAST_BIT) begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (byte_end) begin
                        bit_cnt <= '0;
                        if (st == ST_ADDR) begin
                            if (addr_ok) begin
                                sda_pull <= 1'b1;
                                st       <= ST_ADDR_ACK;
                            end else begin
                                st <= ST_IGNORE;
                            end
                        end else if (room) begin
                            sda_pull <= 1'b1;
                            byte_cnt <= byte_cnt + 1'b1;
                            st       <= ST_DATA_ACK;
                        end else begin
                            st <= ST_IGNORE;
                        end
                    end
                end
                ST_ADDR_ACK, ST_DATA_ACK: begin
                    if (scl_fall) begin
                        sda_pull <= 1'b0;
                        st       <= ST_DATA;
                    end
                end
                default: ;
            endcase
        end
    end

    // Hand a completed, acknowledged data byte to the word assembler
    always_comb begin
        byte_stb  = (st == ST_DATA) && byte_end && room && !start_det && !stop_det;
        byte_idx  = byte_cnt;
        byte_data = shreg;
        state     = st;
    end

endmodule

// File: rtl/i2c_word_asm.sv
// Word assembler: holds early bytes, emits the full word on the last byte.
// Assumes: bytes arrive in index order 0..BYTES-1; index 0 is most significant.
module i2c_word_asm #(
    parameter int  BYTES = 3,
    localparam int IDX_W = $clog2(BYTES + 1),
    localparam int WORD_W = BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_stb,
    input  logic [IDX_W-1:0]  byte_idx,
    input  logic [7:0]        byte_data,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid
);

    logic [WORD_W-1:0] assembled;
    logic              last_stb;

    generate
        for (genvar i = 0; i < BYTES - 1; i++) begin : g_hold
            logic [7:0] held;

            // Capture byte i when it is acknowledged
            always_ff @(posedge clk) begin
                if (!rst_n)                                  held <= '0;
                else if (byte_stb && byte_idx == IDX_W'(i)) held <= byte_data;
            end

            assign assembled[(BYTES-1-i)*8 +: 8] = held;
        end
    endgenerate

    assign assembled[7:0] = byte_data;
    assign last_stb       = byte_stb && (byte_idx == IDX_W'(BYTES - 1));

    // Publish the word and its one-cycle strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out   <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= last_stb;
            if (last_stb) word_out <= assembled;
        end
    end

endmodule

// File: rtl/i2c_word_rx.sv
// Top: write-only I2C target that frames three data bytes into one word.
// Assumes: SCL/SDA oversampled by clk at least ~8x; SDA stable while SCL high
// except for START/STOP; the bus master never stretches or reads.
module i2c_word_rx
    import i2c_word_rx_pkg::*;
#(
    parameter logic [6:0] GLOBAL_ADDR = 7'h73,
    parameter int         SYNC_STAGES = 2,
    parameter int         WORD_BYTES  = 3,
    localparam int        IDX_W       = $clog2(WORD_BYTES + 1),
    localparam int        WORD_W      = WORD_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [6:0]        dev_addr,
    output logic              sda_pull,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid
);

    logic [1:0]       ln_s, ln_rise, ln_fall;
    logic             scl_s, sda_s;
    logic             start_det, stop_det;
    logic             byte_stb;
    logic [IDX_W-1:0] byte_idx;
    logic [7:0]       byte_data;
    frame_st_t        frame_st;

    i2c_line_sync #(
        .STAGES (SYNC_STAGES),
        .LINES  (2)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    ({sda_in, scl_in}),
        .synced (ln_s),
        .rise   (ln_rise),
        .fall   (ln_fall)
    );

    // Qualify bus conditions: SDA edge while SCL held high
    always_comb begin
        scl_s     = ln_s[0];
        sda_s     = ln_s[1];
        start_det = scl_s && !ln_rise[0] && ln_fall[1];
        stop_det  = scl_s && !ln_rise[0] && ln_rise[1];
    end

    i2c_frame_ctrl #(
        .GLOBAL_ADDR (GLOBAL_ADDR),
        .BYTES       (WORD_BYTES)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (ln_rise[0]),
        .scl_fall  (ln_fall[0]),
        .start_det (start_det),
        .stop_det  (stop_det),
        .dev_addr  (dev_addr),
        .sda_pull  (sda_pull),
        .byte_stb  (byte_stb),
        .byte_idx  (byte_idx),
        .byte_data (byte_data),
        .state     (frame_st)
    );

    i2c_word_asm #(
        .BYTES (WORD_BYTES)
    ) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_stb   (byte_stb),
        .byte_idx   (byte_idx),
        .byte_data  (byte_data),
        .word_out   (word_out),
        .word_valid (word_valid)
    );

endmodule

// File: rtl/i2c_word_rx_chk.sv
// Property checker for i2c_word_rx, attached by bind.
// Assumes: SCL low phases last at least four system clocks.
module i2c_word_rx_chk
    import i2c_word_rx_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      scl_in,
    input logic      sda_pull,
    input logic      word_valid,
    input logic      start_det,
    input logic      stop_det,
    input frame_st_t frame_st
);

    logic [3:0] scl_hist;

    // Track how long SCL has been high at the pin
    always_ff @(posedge clk) begin
        if (!rst_n) scl_hist <= '0;
        else        scl_hist <= {scl_hist[2:0], scl_in};
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!sda_pull && !word_valid));

    // R6
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // R4
    ignore_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_st == ST_IGNORE || frame_st == ST_IDLE) |-> !sda_pull);

    // R8
    abort_no_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |=> !word_valid);

    // R10
    ack_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&scl_hist) |-> $stable(sda_pull));

endmodule

bind i2c_word_rx i2c_word_rx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_in     (scl_in),
    .sda_pull   (sda_pull),
    .word_valid (word_valid),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .frame_st   (frame_st)
);

// File: tb/test_i2c_word_rx.sv
`timescale 1ns/1ps
module test_i2c_word_rx;

    localparam logic [6:0] GADDR = 7'h73;
    localparam int         H     = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic [6:0]  dev_addr = 7'h15;
    logic        sda_pull;
    logic [23:0] word_out;
    logic        word_valid;
    logic        sda_in;

    int          vectors = 0;
    int          miscompares = 0;
    logic        exp_pull = 1'b0;
    logic [6:0]  dev_at_start = 7'h00;
    logic [23:0] exp_q[$];
    logic        prev_valid = 1'b0;
    string       cur_req = "R1";

    always #10 clk = ~clk;

    assign sda_in = m_sda & ~sda_pull;

    i2c_word_rx i_i2c_word_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (m_scl),
        .sda_in     (sda_in),
        .dev_addr   (dev_addr),
        .sda_pull   (sda_pull),
        .word_out   (word_out),
        .word_valid (word_valid)
    );

    // Per-clock comparison against the behavioural expectation
    always @(negedge clk) begin
        if (rst_n) begin
            if (m_scl) begin
                vectors++;
                if (sda_pull !== exp_pull) begin
                    miscompares++;
                    $display("FAIL %s/R10 sda_pull actual=%0b expected=%0b t=%0t",
                             cur_req, sda_pull, exp_pull, $time);
                end
            end
            if (word_valid) begin
                vectors++;
                if (prev_valid) begin
                    miscompares++;
                    $display("FAIL R6 strobe longer than one cycle actual=1 expected=0");
                end else if (exp_q.size() == 0) begin
                    miscompares++;
                    $display("FAIL %s unexpected word actual=%h expected=none", cur_req, word_out);
                end else begin
                    logic [23:0] w;
                    w = exp_q.pop_front();
                    if (word_out !== w) begin
                        miscompares++;
                        $display("FAIL R6 word actual=%h expected=%h", word_out, w);
                    end
                end
            end
            prev_valid = word_valid;
        end
    end

    task automatic hp();
        repeat (H) @(posedge clk);
        #5;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; hp();
        m_scl = 1'b1; hp();
        m_sda = 1'b0; hp();
        m_scl = 1'b0;
        dev_at_start = dev_addr;
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hp();
        m_scl = 1'b1; hp();
        m_sda = 1'b1; hp();
    endtask

    task automatic send_byte(input logic [7:0] v, input logic ack);
        for (int b = 7; b >= 0; b--) begin
            m_sda = v[b]; hp();
            m_scl = 1'b1; hp();
            m_scl = 1'b0;
        end
        m_sda = 1'b1;
        exp_pull = ack;
        hp();
        m_scl = 1'b1; hp();
        m_scl = 1'b0;
        exp_pull = 1'b0;
    endtask

    // Address byte plus n data bytes; ACK and word decisions from the model
    task automatic frame_body(input logic [6:0] a, input logic rw,
                              input logic [39:0] d, input int n, input string req);
        logic ok;
        ok = !rw && (a == dev_at_start || a == GADDR);
        cur_req = req;
        send_byte({a, rw}, ok);
        for (int i = 0; i < n; i++) begin
            if (ok && i == 2) exp_q.push_back(d[39 -: 24]);
            send_byte(d[39 - 8*i -: 8], ok && (i < 3));
        end
    endtask

    task automatic check_drained(input string req);
        hp();
        vectors++;
        if (exp_q.size() != 0) begin
            miscompares++;
            $display("FAIL %s word missing actual=none expected=%h", req, exp_q[0]);
            exp_q.delete();
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog (all requirements) actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #5;
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        vectors++;
        if (sda_pull !== 1'b0 || word_valid !== 1'b0) begin
            miscompares++;
            $display("FAIL R1 reset outputs actual=%0b%0b expected=00", sda_pull, word_valid);
        end
        hp();

        // R2 R5 R6: own address, three bytes
        bus_start(); frame_body(7'h15, 1'b0, 40'hA53C81_0000, 3, "R2"); bus_stop();
        check_drained("R5");

        // R3: broadcast address with a different device address
        bus_start(); frame_body(GADDR, 1'b0, 40'h123456_0000, 3, "R3"); bus_stop();
        check_drained("R3");

        // R4: mismatch, then traffic ignored
        bus_start(); frame_body(7'h16, 1'b0, 40'hFFFFFF_0000, 3, "R4"); bus_stop();
        check_drained("R4");

        // R4: read bit set
        bus_start(); frame_body(7'h15, 1'b1, 40'h010203_0000, 3, "R4"); bus_stop();
        check_drained("R4");

        // R7: five bytes, only one word
        bus_start(); frame_body(7'h15, 1'b0, 40'hDEADBEEF55, 5, "R7"); bus_stop();
        check_drained("R7");

        // R8: short frame ended by STOP
        bus_start(); frame_body(7'h15, 1'b0, 40'h77AA00_0000, 2, "R8"); bus_stop();
        check_drained("R8");

        // R8: short frame then repeated START into a full frame
        bus_start(); frame_body(7'h15, 1'b0, 40'h6699CC_0000, 2, "R8");
        bus_start(); frame_body(GADDR, 1'b0, 40'h0F1E2D_0000, 3, "R8"); bus_stop();
        check_drained("R8");

        // R9: address input changes after START
        bus_start();
        dev_addr = 7'h2A;
        frame_body(7'h15, 1'b0, 40'h000000_0000, 3, "R9"); bus_stop();
        check_drained("R9");
        bus_start(); frame_body(7'h2A, 1'b0, 40'hFF00FF_0000, 3, "R9"); bus_stop();
        check_drained("R9");
        bus_start(); frame_body(7'h15, 1'b0, 40'h00FF00_0000, 3, "R9"); bus_stop();
        check_drained("R9");

        // R6: alternating pattern
        bus_start(); frame_body(7'h2A, 1'b0, 40'h5A5AA5_0000, 3, "R6"); bus_stop();
        check_drained("R6");

        summary();
        $finish;
    end

endmodule